// File: doc/BRIEF.md
# ECC Auto-Repair and Patrol Scrub Controller

This controller sits between a host memory request port and a memory array protected by an error-correcting code. An external decoder checks each read response. It reports a single-bit flag, a multi-bit flag and the corrected word. The controller watches those responses and repairs single-bit errors on its own. For each repair it issues a fresh read of the failing word, takes the corrected data from that response and writes it back. Only one repair is ever in flight.

A programmable interval timer drives patrol reads that walk the whole address space one word at a time. Errors found this way are repaired through the same path and are flagged apart from errors seen on host reads. Multi-bit errors are reported and never repaired. A saturating counter, three sticky write-one-to-clear flags and a captured error address give software a view of memory health.

All requests share a single memory port, and the host always wins it. Every request carries a 2-bit source tag, and the memory returns that tag with the response so the controller can tell its own reads apart.

Top module: `ecc_scrub_ctrl`

## Requirements
- R1: When `ecc_en_i` and `fix_en_i` are both high and a host or patrol read response shows a single-bit error (`rsp_sbe_i`=1, `rsp_mbe_i`=0), the block issues a read of that address with source tag 1. It then writes the data returned for that read back to the same address, also with tag 1.
- R2: Each reported single-bit error raises `err_cnt_o` by exactly one. A response tagged 1 (a repair re-read) never changes the counter.
- R3: With patrol enabled, one patrol read (tag 2) is issued every `scrub_int_i` cycles. The patrol address rises by one per read and wraps from 2**AW-1 to 0.
- R4: A single-bit error found by a patrol read is repaired as in R1 and sets `sbe_scrub_o`. A single-bit error on a host read (tag 0) sets `sbe_host_o` instead.
- R5: A multi-bit error (`rsp_mbe_i`=1) on any tag sets `mbe_o`. It is never repaired and never counted.
- R6: A single-bit error at the address currently under repair, seen while that repair is in progress, is neither counted nor flagged.
- R7: Only one repair is in progress at a time. A single-bit error at another address during a repair is counted and flagged, but it is not repaired.
- R8: Repairs and patrol reads need both `ecc_en_i` and `fix_en_i`. With `ecc_en_i` low, no error is counted or flagged. With `fix_en_i` low and `ecc_en_i` high, errors are counted but not repaired.
- R9: A `scrub_int_i` value of zero issues no patrol reads.
- R10: Port priority runs host (tag 0) first, then the repair (tag 1), then the patrol (tag 2). A patrol read that has come due is kept pending until it is issued.
- R11: `err_cnt_o` saturates at 2**CNT_W-1.
- R12: After reset all outputs are zero. The flags are sticky. Writing a one to `clr_i` bit 0 clears `sbe_host_o`, bit 1 clears `sbe_scrub_o` and bit 2 clears `mbe_o`; a new event in the same cycle wins over the clear. `err_addr_o` takes the address of a reported single-bit error only while both single-bit flags are clear.
- R13: A host write to the address under repair, or to the address of an error response seen in the same cycle, cancels that repair's write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ecc_en_i | input | 1 | Global ECC enable |
| fix_en_i | input | 1 | Automatic repair and patrol enable |
| scrub_int_i | input | IW | Patrol interval in cycles, 0 = off |
| host_req_i | input | 1 | Host request valid |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | AW | Host word address |
| host_wdata_i | input | DW | Host write data |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Memory write data |
| mem_src_o | output | 2 | Request source tag: 0 host, 1 repair, 2 patrol |
| rsp_valid_i | input | 1 | Decoded read response valid |
| rsp_src_i | input | 2 | Source tag echoed with the response |
| rsp_addr_i | input | AW | Address of the response |
| rsp_sbe_i | input | 1 | Decoder single-bit error flag |
| rsp_mbe_i | input | 1 | Decoder multi-bit error flag |
| rsp_data_i | input | DW | Corrected read data |
| clr_i | input | 3 | Write-one-to-clear for the three flags |
| err_cnt_o | output | CNT_W | Saturating single-bit error count |
| sbe_host_o | output | 1 | Sticky: single-bit error on a host read |
| sbe_scrub_o | output | 1 | Sticky: single-bit error on a patrol read |
| mbe_o | output | 1 | Sticky: multi-bit error seen |
| err_addr_o | output | AW | Address of the first captured single-bit error |

## Verification
The bench holds a host read on a failing word for two cycles. A design that counted the second sighting during the repair would report two errors for one fault. It also reads two failing words back to back, where a design that queued or overlapped repairs would wrongly clean the second word. It also writes new data to a word just after reading it with an error, and a design without cancellation would overwrite the host data with the stale corrected word. Further cases cover a patrol read deferred by a long host burst and then the interval set to zero; a dropped request would never appear and a re-armed one would appear twice. Counter saturation, patrol wrap and disabled ECC are also targeted, where a bad design would wrap the count, skip addresses or still touch memory.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;
  typedef enum logic [1:0] {
    SRC_HOST   = 2'd0,
    SRC_FIX    = 2'd1,
    SRC_PATROL = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    FX_IDLE,
    FX_RD,
    FX_WAIT,
    FX_WR
  } fx_state_e;
endpackage

// File: rtl/ecc_patrol.sv
module ecc_patrol #(
  parameter int AW = 10,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [IW-1:0] int_i,
  input  logic          gnt_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [IW-1:0] ONE = IW'(1);

  logic [IW-1:0] timer_q;
  logic          pend_q;
  logic          hit;

  assign hit   = en_i && (int_i != '0) && (timer_q == int_i - ONE);
  assign req_o = pend_q && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      pend_q  <= 1'b0;
      addr_o  <= '0;
    end else begin
      if (!en_i || int_i == '0 || hit) timer_q <= '0;
      else                             timer_q <= timer_q + ONE;
      if (gnt_i) begin
        pend_q <= 1'b0;
        addr_o <= addr_o + 1'b1;
      end
      if (hit) pend_q <= 1'b1;
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |=> addr_o == $past(addr_o) + 1'b1);
  // R9
  no_patrol_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_i == '0 && !pend_q) |=> !pend_q);
  // R10
  patrol_retained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i && en_i) |=> (req_o || !en_i));
endmodule

// File: rtl/ecc_fix_fsm.sv
module ecc_fix_fsm
  import ecc_scrub_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          cancel_i,
  input  logic          gnt_i,
  input  logic          rsp_valid_i,
  input  logic [1:0]    rsp_src_i,
  input  logic          rsp_mbe_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          busy_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  fx_state_e state_q;
  logic      rsp_hit;

  assign rsp_hit = rsp_valid_i && (rsp_src_i == SRC_FIX);
  assign busy_o  = state_q != FX_IDLE;
  assign req_o   = (state_q == FX_RD) || (state_q == FX_WR);
  assign we_o    = state_q == FX_WR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FX_IDLE;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      unique case (state_q)
        FX_IDLE: if (start_i) begin
          addr_o  <= start_addr_i;
          state_q <= FX_RD;
        end
        FX_RD: begin
          if (cancel_i)   state_q <= FX_IDLE;
          else if (gnt_i) state_q <= FX_WAIT;
        end
        FX_WAIT: begin
          if (cancel_i) state_q <= FX_IDLE;
          else if (rsp_hit) begin
            if (rsp_mbe_i) state_q <= FX_IDLE;
            else begin
              wdata_o <= rsp_data_i;
              state_q <= FX_WR;
            end
          end
        end
        FX_WR: begin
          if (cancel_i || gnt_i) state_q <= FX_IDLE;
        end
        default: state_q <= FX_IDLE;
      endcase
    end
  end

  // R1
  writeback_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FX_WAIT && rsp_hit && !rsp_mbe_i && !cancel_i)
      |=> (req_o && we_o && wdata_o == $past(rsp_data_i)));
  // R13
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cancel_i) |=> !busy_o);
endmodule

// File: rtl/ecc_err_status.sv
module ecc_err_status
  import ecc_scrub_pkg::*;
#(
  parameter int AW    = 10,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ecc_en_i,
  input  logic             rsp_valid_i,
  input  logic [1:0]       rsp_src_i,
  input  logic [AW-1:0]    rsp_addr_i,
  input  logic             rsp_sbe_i,
  input  logic             rsp_mbe_i,
  input  logic             fix_busy_i,
  input  logic [AW-1:0]    fix_addr_i,
  input  logic [2:0]       clr_i,
  output logic             report_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sbe_host_o,
  output logic             sbe_scrub_o,
  output logic             mbe_o,
  output logic [AW-1:0]    err_addr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic sbe_seen, dup, mbe_seen;

  assign sbe_seen = ecc_en_i && rsp_valid_i && rsp_sbe_i && !rsp_mbe_i
                    && (rsp_src_i != SRC_FIX);
  assign dup      = fix_busy_i && (rsp_addr_i == fix_addr_i);
  assign report_o = sbe_seen && !dup;
  assign mbe_seen = ecc_en_i && rsp_valid_i && rsp_mbe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= '0;
      sbe_host_o  <= 1'b0;
      sbe_scrub_o <= 1'b0;
      mbe_o       <= 1'b0;
      err_addr_o  <= '0;
    end else begin
      if (report_o && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      if (report_o && !sbe_host_o && !sbe_scrub_o) err_addr_o <= rsp_addr_i;

      if (report_o && rsp_src_i == SRC_HOST)        sbe_host_o <= 1'b1;
      else if (clr_i[0])                            sbe_host_o <= 1'b0;
      if (report_o && rsp_src_i == SRC_PATROL)      sbe_scrub_o <= 1'b1;
      else if (clr_i[1])                            sbe_scrub_o <= 1'b0;
      if (mbe_seen)                                 mbe_o <= 1'b1;
      else if (clr_i[2])                            mbe_o <= 1'b0;
    end
  end

  // R2
  reread_not_counted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_src_i == SRC_FIX) |=> $stable(cnt_o));
  // R11
  cnt_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
  // R12
  host_flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_host_o && !clr_i[0]) |=> sbe_host_o);
endmodule

// File: rtl/ecc_scrub_ctrl.sv
module ecc_scrub_ctrl
  import ecc_scrub_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int CNT_W = 8,
  parameter int IW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ecc_en_i,
  input  logic             fix_en_i,
  input  logic [IW-1:0]    scrub_int_i,
  input  logic             host_req_i,
  input  logic             host_we_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [DW-1:0]    host_wdata_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic [1:0]       mem_src_o,
  input  logic             rsp_valid_i,
  input  logic [1:0]       rsp_src_i,
  input  logic [AW-1:0]    rsp_addr_i,
  input  logic             rsp_sbe_i,
  input  logic             rsp_mbe_i,
  input  logic [DW-1:0]    rsp_data_i,
  input  logic [2:0]       clr_i,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             sbe_host_o,
  output logic             sbe_scrub_o,
  output logic             mbe_o,
  output logic [AW-1:0]    err_addr_o
);
  logic          fix_active, report;
  logic          fix_start, fix_cancel, fix_busy, fix_req, fix_we, fix_gnt;
  logic [AW-1:0] fix_addr, pat_addr;
  logic [DW-1:0] fix_wdata;
  logic          pat_req, pat_gnt;
  logic          host_wr;

  assign fix_active = ecc_en_i && fix_en_i;
  assign host_wr    = host_req_i && host_we_i;
  assign fix_start  = report && fix_active && !fix_busy
                      && !(host_wr && host_addr_i == rsp_addr_i);
  assign fix_cancel = host_wr && (host_addr_i == fix_addr);
  assign fix_gnt    = fix_req && !host_req_i;
  assign pat_gnt    = pat_req && !host_req_i && !fix_req;

  ecc_err_status #(.AW(AW), .CNT_W(CNT_W)) u_status (
    .clk_i, .rst_ni,
    .ecc_en_i,
    .rsp_valid_i, .rsp_src_i, .rsp_addr_i, .rsp_sbe_i, .rsp_mbe_i,
    .fix_busy_i (fix_busy),
    .fix_addr_i (fix_addr),
    .clr_i,
    .report_o   (report),
    .cnt_o      (err_cnt_o),
    .sbe_host_o, .sbe_scrub_o, .mbe_o, .err_addr_o
  );

  ecc_fix_fsm #(.AW(AW), .DW(DW)) u_fix (
    .clk_i, .rst_ni,
    .start_i      (fix_start),
    .start_addr_i (rsp_addr_i),
    .cancel_i     (fix_cancel),
    .gnt_i        (fix_gnt),
    .rsp_valid_i, .rsp_src_i, .rsp_mbe_i, .rsp_data_i,
    .busy_o       (fix_busy),
    .req_o        (fix_req),
    .we_o         (fix_we),
    .addr_o       (fix_addr),
    .wdata_o      (fix_wdata)
  );

  ecc_patrol #(.AW(AW), .IW(IW)) u_patrol (
    .clk_i, .rst_ni,
    .en_i   (fix_active),
    .int_i  (scrub_int_i),
    .gnt_i  (pat_gnt),
    .req_o  (pat_req),
    .addr_o (pat_addr)
  );

  always_comb begin
    mem_req_o   = host_req_i || fix_req || pat_req;
    mem_we_o    = 1'b0;
    mem_addr_o  = pat_addr;
    mem_wdata_o = '0;
    mem_src_o   = SRC_PATROL;
    if (host_req_i) begin
      mem_we_o    = host_we_i;
      mem_addr_o  = host_addr_i;
      mem_wdata_o = host_wdata_i;
      mem_src_o   = SRC_HOST;
    end else if (fix_req) begin
      mem_we_o    = fix_we;
      mem_addr_o  = fix_addr;
      mem_wdata_o = fix_wdata;
      mem_src_o   = SRC_FIX;
    end
  end

  // R8
  no_patrol_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fix_active |-> !(mem_req_o && mem_src_o == SRC_PATROL));
  // R7
  single_repair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_busy && report && rsp_addr_i != fix_addr) |=> fix_addr == $past(fix_addr));
endmodule

// File: tb/ecc_scrub_ctrl_tb.sv
module ecc_scrub_ctrl_tb;
  localparam int AW = 4, DW = 16, CNT_W = 8, IW = 8;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ecc_en = 1'b1, fix_en = 1'b1;
  logic [IW-1:0] scrub_int = '0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [2:0] clr = '0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [1:0] mem_src;
  logic rsp_valid = 1'b0, rsp_sbe = 1'b0, rsp_mbe = 1'b0;
  logic [1:0] rsp_src = '0;
  logic [AW-1:0] rsp_addr = '0;
  logic [DW-1:0] rsp_data = '0;
  logic [CNT_W-1:0] err_cnt;
  logic sbe_host, sbe_scrub, mbe;
  logic [AW-1:0] err_addr;

  ecc_scrub_ctrl #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .IW(IW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ecc_en_i(ecc_en), .fix_en_i(fix_en),
    .scrub_int_i(scrub_int), .host_req_i(host_req), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_src_o(mem_src),
    .rsp_valid_i(rsp_valid), .rsp_src_i(rsp_src), .rsp_addr_i(rsp_addr),
    .rsp_sbe_i(rsp_sbe), .rsp_mbe_i(rsp_mbe), .rsp_data_i(rsp_data),
    .clr_i(clr), .err_cnt_o(err_cnt), .sbe_host_o(sbe_host),
    .sbe_scrub_o(sbe_scrub), .mbe_o(mbe), .err_addr_o(err_addr)
  );

  // memory model: data plus injected error kind (0 none, 1 single, 2 multi)
  logic [DW-1:0] mdata [WORDS];
  logic [1:0]    merr  [WORDS];
  logic inj_v = 1'b0;
  logic [AW-1:0] inj_a = '0;
  logic [1:0] inj_k = '0;
  logic [DW-1:0] inj_d = '0;
  int patrol_cnt = 0, seq_bad = 0, alien_cnt = 0;
  logic [AW-1:0] exp_pa = '0;

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        mdata[i] <= '0;
        merr[i]  <= '0;
      end
    end else begin
      if (inj_v) begin
        mdata[inj_a] <= inj_d;
        merr[inj_a]  <= inj_k;
      end
      if (mem_req) begin
        if (host_req && mem_src != 2'd0) alien_cnt <= alien_cnt + 1;
        if (mem_we) begin
          mdata[mem_addr] <= mem_wdata;
          merr[mem_addr]  <= '0;
        end else begin
          rsp_valid <= 1'b1;
          rsp_src   <= mem_src;
          rsp_addr  <= mem_addr;
          rsp_data  <= mdata[mem_addr];
          rsp_sbe   <= merr[mem_addr] == 2'd1;
          rsp_mbe   <= merr[mem_addr] == 2'd2;
        end
        if (mem_src == 2'd2) begin
          patrol_cnt <= patrol_cnt + 1;
          if (mem_addr != exp_pa) seq_bad <= seq_bad + 1;
          exp_pa <= mem_addr + 1'b1;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == {CNT_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [1:0] k, input logic [DW-1:0] d);
    @(negedge clk);
    inj_v = 1'b1; inj_a = a; inj_k = k; inj_d = d;
    @(negedge clk);
    inj_v = 1'b0;
  endtask

  task automatic host_rd(input logic [AW-1:0] a, input int cyc);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    repeat (cyc) @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic clear_flags(input logic [2:0] m);
    @(negedge clk);
    clr = m;
    @(negedge clk);
    clr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] c0;
    int p0;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 reset cnt", 32'(err_cnt), 0);
    check("R12 reset flags", {sbe_host, sbe_scrub, mbe}, 0);
    check("R12 reset mem_req", 32'(mem_req), 0);

    // R1 R2 R4 host single-bit repair
    inject(4'd3, 2'd1, 16'h1234);
    c0 = err_cnt;
    host_rd(4'd3, 1);
    idle(8);
    check("R1 repaired err", 32'(merr[3]), 0);
    check("R1 repaired data", 32'(mdata[3]), 32'h1234);
    check("R2 counted once", 32'(err_cnt), 32'(sat_inc(c0)));
    check("R4 host flag", {sbe_host, sbe_scrub}, 2'b10);
    check("R12 err_addr first", 32'(err_addr), 3);

    // R5 multi-bit
    inject(4'd5, 2'd2, 16'h5555);
    c0 = err_cnt;
    host_rd(4'd5, 1);
    idle(8);
    check("R5 mbe flag", 32'(mbe), 1);
    check("R5 not counted", 32'(err_cnt), 32'(c0));
    check("R5 not repaired", 32'(merr[5]), 2);
    clear_flags(3'b111);
    check("R12 w1c", {sbe_host, sbe_scrub, mbe}, 0);

    // R6 duplicate at the address under repair
    inject(4'd7, 2'd1, 16'h0707);
    c0 = err_cnt;
    host_rd(4'd7, 2);
    idle(10);
    check("R6 no double count", 32'(err_cnt), 32'(sat_inc(c0)));
    check("R6 repaired", 32'(merr[7]), 0);

    // R7 second address during repair
    inject(4'd8, 2'd1, 16'h0808);
    inject(4'd9, 2'd1, 16'h0909);
    c0 = err_cnt;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 4'd8;
    @(negedge clk);
    host_addr = 4'd9;
    @(negedge clk);
    host_req = 1'b0;
    idle(10);
    check("R7 both counted", 32'(err_cnt), 32'(sat_inc(sat_inc(c0))));
    check("R7 first repaired", 32'(merr[8]), 0);
    check("R7 second left", 32'(merr[9]), 1);
    host_rd(4'd9, 1);
    idle(10);

    // R13 host write cancels write-back
    inject(4'd10, 2'd1, 16'h1111);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 4'd10;
    @(negedge clk);
    host_we = 1'b1; host_wdata = 16'h2222;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
    idle(10);
    check("R13 host data kept", 32'(mdata[10]), 32'h2222);

    // R8 fix disabled / ecc disabled
    fix_en = 1'b0;
    inject(4'd11, 2'd1, 16'h0b0b);
    c0 = err_cnt;
    host_rd(4'd11, 1);
    idle(8);
    check("R8 fix off counted", 32'(err_cnt), 32'(sat_inc(c0)));
    check("R8 fix off not repaired", 32'(merr[11]), 1);
    fix_en = 1'b1; ecc_en = 1'b0; scrub_int = 8'd4;
    c0 = err_cnt; p0 = patrol_cnt;
    host_rd(4'd11, 1);
    idle(40);
    check("R8 ecc off no count", 32'(err_cnt), 32'(c0));
    check("R8 ecc off no repair", 32'(merr[11]), 1);
    check("R8 ecc off no patrol", 32'(patrol_cnt - p0), 0);

    // R9 zero interval
    ecc_en = 1'b1; scrub_int = '0;
    p0 = patrol_cnt;
    idle(100);
    check("R9 no patrol", 32'(patrol_cnt - p0), 0);

    // R3 R4 patrol cadence, wrap, scrub flag
    clear_flags(3'b111);
    c0 = err_cnt; p0 = patrol_cnt;
    @(negedge clk);
    scrub_int = 8'd5;
    idle(100);
    scrub_int = '0;
    idle(10);
    check("R3 patrol rate", 32'((patrol_cnt - p0) >= 18 && (patrol_cnt - p0) <= 21), 1);
    check("R3 address order and wrap", 32'(seq_bad), 0);
    check("R4 scrub repaired", 32'(merr[11]), 0);
    check("R4 scrub flag", {sbe_host, sbe_scrub}, 2'b01);
    check("R4 scrub counted", 32'(err_cnt), 32'(sat_inc(c0)));

    // R10 host priority and retained patrol
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 4'd0; scrub_int = 8'd3;
    p0 = patrol_cnt;
    alien_cnt = alien_cnt;
    repeat (30) @(negedge clk);
    check("R10 host blocks patrol", 32'(patrol_cnt - p0), 0);
    check("R10 no internal traffic", 32'(alien_cnt), 0);
    scrub_int = '0; host_req = 1'b0;
    idle(5);
    check("R10 deferred patrol issued once", 32'(patrol_cnt - p0), 1);

    // R1 R2 R5 random
    clear_flags(3'b111);
    for (int it = 0; it < 40; it++) begin
      logic [AW-1:0] a;
      logic [1:0] k;
      logic [DW-1:0] d;
      a = AW'($urandom % WORDS);
      k = 2'($urandom % 3);
      d = DW'($urandom);
      inject(a, k, d);
      c0 = err_cnt;
      host_rd(a, 1);
      idle(8);
      check("R2 random count", 32'(err_cnt), (k == 2'd1) ? 32'(sat_inc(c0)) : 32'(c0));
      if (k == 2'd1) check("R1 random repair", {merr[a], mdata[a]}, {2'd0, d});
      if (k == 2'd2) begin
        check("R5 random mbe", {mbe, merr[a]}, {1'b1, 2'd2});
        inject(a, 2'd0, d);
        clear_flags(3'b100);
      end
    end

    // R12 err_addr capture
    clear_flags(3'b111);
    inject(4'd13, 2'd1, 16'hd);
    inject(4'd14, 2'd1, 16'he);
    host_rd(4'd13, 1);
    idle(8);
    host_rd(4'd14, 1);
    idle(8);
    check("R12 first address held", 32'(err_addr), 13);
    clear_flags(3'b011);
    inject(4'd2, 2'd1, 16'h2);
    host_rd(4'd2, 1);
    idle(8);
    check("R12 recapture after clear", 32'(err_addr), 2);

    // R11 saturation
    for (int it = 0; it < 260; it++) begin
      inject(4'd12, 2'd1, 16'hc);
      host_rd(4'd12, 1);
      idle(6);
    end
    check("R11 saturated", 32'(err_cnt), 32'({CNT_W{1'b1}}));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule